// File: doc/BRIEF.md
# Group Cell Rate Pacer

This block decides when the receive side of an inverse-multiplexed ATM group processes its next cell. It has two modes. In demand mode, every cell write into the delay compensation buffer produces one processing trigger a cycle later, and no timer is involved. In rate mode, the block first learns the cell period of the timing reference link. It stamps each service request from that link with a free-running master timer and averages sixteen successive gaps. It then turns that average into a pacing period. The period is divided by the number of links in the group and multiplied by 2049/2048, which removes the one stuff cell the reference link carries in every 2049. Once the timer is enabled, triggers are produced at that period.

The pacing period is kept in fixed point with eight fractional bits. A fractional phase accumulator produces the triggers, so the long-run rate follows the learned value exactly and does not drift. Changing the mode or the link count discards what was learned and starts learning again.

Top module: `ima_cell_pacer`

## Requirements
- R1: With `mode_i` = 0 (demand), `trig_o` is high in the cycle after each cycle in which `buf_wr_i` is high, and low in the cycle after each cycle in which it is low. `ref_req_i` and `tmr_en_i` have no effect on `trig_o` in this mode.
- R2: With `mode_i` = 1 (rate), `buf_wr_i` has no effect on `trig_o`.
- R3: In rate mode, learning works as follows:
  - The first `ref_req_i` after a restart only records a timestamp.
  - Each later request adds its gap to the earlier one to a running sum. Gaps are measured on a free-running TS_W-bit timer with modulo subtraction, so timer wraparound does not disturb the result.
  - The average is floor(sum/16), computed after 16 gaps.
  - After only 16 requests, `period_valid_o` stays low.
- R4: After learning completes, `period_o` = floor(avg·2049 / (8·Neff)). This is the period in clock cycles with 8 fractional bits. Neff is `link_cnt_i`, or 1 when `link_cnt_i` is 0, and counts up to 15 are supported. `period_valid_o` rises within 40 cycles of the request that completes learning.
- R5: In rate mode with `period_valid_o` high, `tmr_en_i` is raised and then held for M cycles. The number of `trig_o` pulses in those M cycles is exactly floor(M·256 / P). P is `period_o`, but never less than 512.
- R6: In rate mode, no trigger is produced while `tmr_en_i` is low or `period_valid_o` is low.
- R7: A change of `mode_i` or `link_cnt_i` drops `period_valid_o` in the next cycle and restarts learning from the first request.
- R8: In rate mode a trigger is a single-cycle pulse, and two triggers never fall in consecutive cycles.
- R9: After reset, `trig_o`, `period_o` and `period_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_req_i | input | 1 | Service request strobe from the timing reference link |
| buf_wr_i | input | 1 | Cell written into the delay compensation buffer |
| link_cnt_i | input | LINK_W | Number of links in the group |
| mode_i | input | 1 | 0 = demand, 1 = rate |
| tmr_en_i | input | 1 | Enables the group's rate timer |
| trig_o | output | 1 | Cell-processing trigger pulse |
| period_o | output | TS_W+9 | Learned pacing period, 8 fractional bits |
| period_valid_o | output | 1 | Pacing period learned and valid |

## Verification
Several properties are checked on every cycle:
- the one-cycle echo of buffer writes in demand mode;
- the silence of the rate path while it is disabled or unlearned;
- the drop of validity after a restart;
- the absence of back-to-back rate triggers;
- the accumulator staying below the effective period;
- the divider's remainder staying below its divisor.

Some behaviour only the bench scenarios can show. These are the learned average for uniform gaps and for uneven gaps that wrap the timer, the exact scaled period for several link counts including zero, the exact trigger count over long windows, and the rule that the first request after a restart is only a reference.

// File: rtl/ima_pacer_pkg.sv
package ima_pacer_pkg;
  typedef enum logic {
    MODE_DEMAND = 1'b0,
    MODE_RATE   = 1'b1
  } pace_mode_e;

  // stuff-cell correction: one stuff per 2049 cells on the reference link
  localparam int unsigned STUFF_MUL   = 2049;
  localparam int unsigned STUFF_SHIFT = 11;
  localparam int unsigned MUL_W       = 12;
endpackage

// File: rtl/ima_gap_learner.sv
module ima_gap_learner #(
  parameter int unsigned TS_W     = 16,
  parameter int unsigned WIN_LOG2 = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            learn_i,
  input  logic            req_i,
  output logic [TS_W-1:0] avg_o,
  output logic            avg_stb_o
);
  localparam int unsigned WIN   = 1 << WIN_LOG2;
  localparam int unsigned SUM_W = TS_W + WIN_LOG2;

  logic [TS_W-1:0]     ts_q, prev_q, gap, avg_q;
  logic [SUM_W-1:0]    sum_q, sum_nxt;
  logic [WIN_LOG2-1:0] cnt_q;
  logic                have_prev_q, done_q, stb_q;

  assign gap     = ts_q - prev_q;  // modulo difference absorbs wraparound
  assign sum_nxt = sum_q + SUM_W'(gap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q        <= '0;
      prev_q      <= '0;
      sum_q       <= '0;
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      avg_q       <= '0;
      stb_q       <= 1'b0;
    end else begin
      ts_q  <= ts_q + 1'b1;
      stb_q <= 1'b0;
      if (clr_i || !learn_i) begin
        sum_q       <= '0;
        cnt_q       <= '0;
        have_prev_q <= 1'b0;
        done_q      <= 1'b0;
      end else if (req_i && !done_q) begin
        prev_q <= ts_q;
        if (!have_prev_q) begin
          have_prev_q <= 1'b1;
        end else begin
          sum_q <= sum_nxt;
          if (cnt_q == WIN_LOG2'(WIN - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            stb_q  <= 1'b1;
            avg_q  <= sum_nxt[SUM_W-1:WIN_LOG2];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign avg_o     = avg_q;
  assign avg_stb_o = stb_q;

  p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_stb_o |=> !avg_stb_o);
  p_stb_needs_learn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || !learn_i) |=> !avg_stb_o);
endmodule

// File: rtl/ima_rate_divider.sv
module ima_rate_divider
  import ima_pacer_pkg::*;
#(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned LINK_W = 4,
  parameter int unsigned FRAC   = 8,
  parameter int unsigned PER_W  = TS_W + FRAC + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [TS_W-1:0]   avg_i,
  input  logic [LINK_W-1:0] links_i,
  output logic [PER_W-1:0]  period_o,
  output logic              valid_o
);
  localparam int unsigned NUM_W  = TS_W + MUL_W;
  localparam int unsigned DEN_W  = LINK_W + STUFF_SHIFT - FRAC;
  localparam int unsigned STEP_W = $clog2(NUM_W);

  logic [NUM_W-1:0]  num, quo_q, quo_nxt;
  logic [DEN_W-1:0]  den_q, den_nxt, rem_q, rem_nxt;
  logic [DEN_W:0]    rem_sh;
  logic [LINK_W-1:0] neff;
  logic [STEP_W-1:0] step_q;
  logic [PER_W-1:0]  per_q;
  logic              busy_q, valid_q, ge;

  assign neff    = (links_i == '0) ? LINK_W'(1) : links_i;
  assign num     = NUM_W'(avg_i) * NUM_W'(STUFF_MUL);
  // 2^FRAC / 2^STUFF_SHIFT folds into the divisor
  assign den_nxt = DEN_W'(neff) << (STUFF_SHIFT - FRAC);

  // restoring division, one quotient bit per cycle
  assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
  assign ge      = rem_sh >= {1'b0, den_q};
  assign rem_nxt = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
  assign quo_nxt = {quo_q[NUM_W-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      step_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      per_q   <= '0;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
      step_q  <= '0;
      rem_q   <= '0;
      quo_q   <= num;
      den_q   <= den_nxt;
    end else if (busy_q) begin
      rem_q  <= rem_nxt;
      quo_q  <= quo_nxt;
      step_q <= step_q + 1'b1;
      if (step_q == STEP_W'(NUM_W - 1)) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        per_q   <= PER_W'(quo_nxt);
      end
    end
  end

  assign period_o = per_q;
  assign valid_o  = valid_q;

  p_den_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> den_q != '0);
  p_rem_below_den_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < den_q);
  p_valid_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_q);
endmodule

// File: rtl/ima_trig_gen.sv
module ima_trig_gen
  import ima_pacer_pkg::*;
#(
  parameter int unsigned FRAC  = 8,
  parameter int unsigned PER_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pace_mode_e       mode_i,
  input  logic             buf_wr_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             trig_o
);
  localparam logic [PER_W-1:0] PER_MIN = PER_W'(2) << FRAC;
  localparam logic [PER_W:0]   STEP    = (PER_W + 1)'(1) << FRAC;

  logic [PER_W-1:0] acc_q, per_eff;
  logic [PER_W:0]   acc_nx;
  logic             hit, rate_q, dem_q;

  // floor of two cycles keeps rate triggers from touching
  assign per_eff = (period_i < PER_MIN) ? PER_MIN : period_i;
  assign acc_nx  = {1'b0, acc_q} + STEP;
  assign hit     = acc_nx >= {1'b0, per_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rate_q <= 1'b0;
      dem_q  <= 1'b0;
    end else begin
      dem_q <= (mode_i == MODE_DEMAND) && buf_wr_i;
      if (!run_i) begin
        acc_q  <= '0;
        rate_q <= 1'b0;
      end else begin
        rate_q <= hit;
        acc_q  <= hit ? PER_W'(acc_nx - {1'b0, per_eff}) : PER_W'(acc_nx);
      end
    end
  end

  assign trig_o = dem_q | rate_q;

  p_rate_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q |=> !rate_q);
  p_acc_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> acc_q < per_eff);
endmodule

// File: rtl/ima_cell_pacer.sv
module ima_cell_pacer
  import ima_pacer_pkg::*;
#(
  parameter int unsigned TS_W     = 16,
  parameter int unsigned LINK_W   = 4,
  parameter int unsigned WIN_LOG2 = 4,
  parameter int unsigned FRAC     = 8,
  localparam int unsigned PER_W   = TS_W + FRAC + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_req_i,
  input  logic              buf_wr_i,
  input  logic [LINK_W-1:0] link_cnt_i,
  input  logic              mode_i,
  input  logic              tmr_en_i,
  output logic              trig_o,
  output logic [PER_W-1:0]  period_o,
  output logic              period_valid_o
);
  pace_mode_e        mode, mode_q;
  logic [LINK_W-1:0] link_q;
  logic [TS_W-1:0]   avg;
  logic              avg_stb, restart, rate_mode, run, valid;

  assign mode      = pace_mode_e'(mode_i);
  assign rate_mode = (mode == MODE_RATE);
  assign restart   = (mode != mode_q) || (link_cnt_i != link_q);
  assign run       = rate_mode && tmr_en_i && valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DEMAND;
      link_q <= '0;
    end else begin
      mode_q <= mode;
      link_q <= link_cnt_i;
    end
  end

  ima_gap_learner #(
    .TS_W     (TS_W),
    .WIN_LOG2 (WIN_LOG2)
  ) u_learn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (restart),
    .learn_i   (rate_mode),
    .req_i     (ref_req_i),
    .avg_o     (avg),
    .avg_stb_o (avg_stb)
  );

  ima_rate_divider #(
    .TS_W   (TS_W),
    .LINK_W (LINK_W),
    .FRAC   (FRAC),
    .PER_W  (PER_W)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart),
    .start_i  (avg_stb),
    .avg_i    (avg),
    .links_i  (link_cnt_i),
    .period_o (period_o),
    .valid_o  (valid)
  );

  ima_trig_gen #(
    .FRAC  (FRAC),
    .PER_W (PER_W)
  ) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .buf_wr_i (buf_wr_i),
    .run_i    (run),
    .period_i (period_o),
    .trig_o   (trig_o)
  );

  assign period_valid_o = valid;

  p_demand_echo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && buf_wr_i) |=> trig_o);
  p_demand_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !buf_wr_i) |=> !trig_o);
  p_rate_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !(tmr_en_i && period_valid_o)) |=> !trig_o);
  p_restart_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !period_valid_o);
endmodule

// File: tb/sim_ima_cell_pacer.sv
`timescale 1ns/1ps
module sim_ima_cell_pacer;
  localparam int TS_W   = 12;
  localparam int LINK_W = 4;
  localparam int PER_W  = TS_W + 9;

  typedef struct packed {
    int gap;
    int links;
    int win;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{40,  8, 2000},
    '{100, 1, 3000},
    '{257, 3, 3000},
    '{300, 0, 2000},
    '{3,   8, 100},
    '{300, 15, 2000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_req = 1'b0, buf_wr = 1'b0, mode = 1'b0, tmr_en = 1'b0;
  logic [LINK_W-1:0] links = '0;
  logic              trig, valid;
  logic [PER_W-1:0]  period;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ima_cell_pacer #(.TS_W(TS_W), .LINK_W(LINK_W)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ref_req_i      (ref_req),
    .buf_wr_i       (buf_wr),
    .link_cnt_i     (links),
    .mode_i         (mode),
    .tmr_en_i       (tmr_en),
    .trig_o         (trig),
    .period_o       (period),
    .period_valid_o (valid)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic req_train(input int gap, input int n);
    for (int k = 0; k < n; k++) begin
      ref_req = 1'b1;
      @(negedge clk);
      ref_req = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 80 && !got; k++) begin
      @(negedge clk);
      got = valid;
    end
  endtask

  task automatic relearn(input int l);
    mode = 1'b0;
    repeat (2) @(negedge clk);
    mode  = 1'b1;
    links = LINK_W'(l);
    repeat (2) @(negedge clk);
  endtask

  task automatic count_window(input int m, output int cnt, output bit b2b);
    bit prev = 1'b0;
    cnt = 0;
    b2b = 1'b0;
    tmr_en = 1'b1;
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      if (trig) cnt++;
      if (trig && prev) b2b = 1'b1;
      prev = trig;
    end
    tmr_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic longint exp_period(input longint avg, input int l);
    longint ne = (l == 0) ? 1 : l;
    return (avg * 2049) / (8 * ne);
  endfunction

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit     got, b2b;
    int     cnt;
    longint p, eff, sum;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(trig == 1'b0, "R9 trig", trig, 0);
    chk(period == '0, "R9 period", period, 0);
    chk(valid == 1'b0, "R9 valid", valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 demand mode echoes buffer writes; requests and enable ignored
    tmr_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = 1'(16'hB5A3 >> i);
      buf_wr  = b;
      ref_req = ~b;
      @(negedge clk);
      chk(trig == b, "R1 demand echo", trig, b);
    end
    buf_wr = 1'b0;
    ref_req = 1'b0;
    tmr_en = 1'b0;
    @(negedge clk);

    // table: uniform gaps, several link counts
    foreach (VECS[v]) begin
      relearn(VECS[v].links);
      req_train(VECS[v].gap, 17);
      wait_valid(got);
      p = exp_period(VECS[v].gap, VECS[v].links);
      chk(got, "R4 valid rises", got, 1);
      chk(longint'(period) == p, "R4 period", period, p);
      eff = (p < 512) ? 512 : p;
      count_window(VECS[v].win, cnt, b2b);
      chk(longint'(cnt) == (longint'(VECS[v].win) * 256) / eff, "R5 trigger count",
          cnt, (longint'(VECS[v].win) * 256) / eff);
      chk(!b2b, "R8 no back-to-back", b2b, 0);
    end

    // R2 and R6: valid, timer disabled, buffer writes toggling
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      buf_wr = 1'(i);
      @(negedge clk);
      if (trig) cnt++;
    end
    buf_wr = 1'b0;
    chk(cnt == 0, "R2/R6 disabled rate mode silent", cnt, 0);

    // R7 link count change drops valid
    links = 4'd5;
    @(negedge clk);
    chk(valid == 1'b0, "R7 valid drops", valid, 0);

    // R6 not valid yet but enabled: no triggers
    count_window(150, cnt, b2b);
    chk(cnt == 0, "R6 unlearned silent", cnt, 0);

    // R3 uneven gaps wrapping the 12-bit timer; first request is reference only
    sum = 0;
    for (int i = 0; i < 16; i++) begin
      ref_req = 1'b1;
      @(negedge clk);
      ref_req = 1'b0;
      repeat (200 + 37 * i - 1) @(negedge clk);
      sum += 200 + 37 * i;
    end
    repeat (60) @(negedge clk);
    chk(valid == 1'b0, "R3 sixteen requests not enough", valid, 0);
    ref_req = 1'b1;
    @(negedge clk);
    ref_req = 1'b0;
    wait_valid(got);
    p = exp_period(sum / 16 + 60, 5);
    chk(got, "R3 valid after window", got, 1);
    // last gap was lengthened by the 60-cycle wait
    p = exp_period((sum + 60) / 16, 5);
    chk(longint'(period) == p, "R3 wrapped average period", period, p);

    // R7 mode change also drops valid
    mode = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R7 mode change drop", valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule